// File: doc/BRIEF.md
# USB Host IN Endpoint Sequencer

This block runs IN transfers for a single receive endpoint of a USB host. A register write arms a request. The block then asks an abstract transaction engine to send an IN token, and waits for one outcome code from that engine. When a data packet lands in the external receive FIFO, the block raises a receive-ready flag and gives a one-cycle interrupt pulse. When the packet has been unloaded, it pulses an acknowledge request back to the engine.

For bulk streaming, the block can re-arm itself each time a packet is unloaded. Such a run ends in one of two ways: a programmed packet budget runs out, or, when the budget is zero, a packet shorter than the maximum payload arrives. The block can also drop receive-ready by itself once a full-size packet has been read out.

NAKs are retried up to a programmable limit. Timeouts and CRC or bit-stuff errors are retried up to three attempts. A STALL ends the request at once. Each of these endings sets its own sticky flag.

Top module: `usb_in_ep_seq`

## Requirements
- R1: After reset, every output is 0 and no token is requested until `req_set` is pulsed. While the request bit is 1, `rx_rdy` is 0 and no response is pending, `tok_req` is 1 for exactly one cycle per attempt.
- R2: A response with `rsp_code` 0 (data) sets `rx_rdy`, clears `req_bit`, and drives `rx_irq` high for exactly one cycle.
- R3: Pulsing `rxrdy_clr` while `rx_rdy` is 1 clears `rx_rdy` and drives `ack_pulse` high for one cycle.
- R4: When `auto_clr_en` is 1 and the stored packet length equals `max_pay`, the `max_pay`-th `fifo_rd` pulse clears `rx_rdy` and pulses `ack_pulse`. Shorter packets, or `auto_clr_en` equal to 0, keep `rx_rdy` set whatever the number of reads.
- R5: When `auto_req` is 1, every unload sets `req_bit` again in the same cycle that `rx_rdy` falls.
- R6: Each arming (a software pulse on an idle request bit, or an automatic re-arm) decrements a nonzero `pkt_cnt`. The decrement that reaches 0 clears `auto_req`, so a budget of N yields exactly N packets.
- R7: With `pkt_cnt` equal to 0, `auto_req` stays 1 through full-size packets. A data packet whose `rsp_len` is below `max_pay` clears it.
- R8: A response with `rsp_code` 1 (NAK) retries the token. When `nak_limit` is nonzero, the `nak_limit`-th consecutive NAK clears `req_bit` and sets `nak_to`.
- R9: A `nak_limit` of 0 retries NAKs without bound and never sets `nak_to`.
- R10: A response with `rsp_code` 2 (STALL) clears `req_bit`, sets `stalled`, and issues no retry.
- R11: Codes 3 (timeout), 4 (CRC error) and 5 (bit-stuff error) are retried. The third consecutive one clears `req_bit` and sets `err_flag`.
- R12: The NAK and error counters restart at zero on every arming and on every data response.
- R13: `sts_clr` or a software arm clears `stalled`, `err_flag` and `nak_to`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 1 | Software pulse that arms a request |
| rxrdy_clr | input | 1 | Software pulse: packet unloaded |
| sts_clr | input | 1 | Pulse that clears the sticky outcome flags |
| auto_clr_en | input | 1 | Enable clearing of receive-ready after a full-size read-out |
| autoreq_wr | input | 1 | Write strobe for the auto-request bit |
| autoreq_val | input | 1 | Value written to the auto-request bit |
| cnt_wr | input | 1 | Write strobe for the packet budget |
| cnt_val | input | CNT_W | Packet budget value |
| max_pay | input | MAXP_W | Maximum payload size |
| nak_limit | input | NAKL_W | NAK limit (0 means unlimited) |
| fifo_rd | input | 1 | One unit read from the receive FIFO |
| tok_req | output | 1 | Request to send one IN token |
| rsp_valid | input | 1 | Engine outcome valid |
| rsp_code | input | 3 | Outcome code: 0 data, 1 NAK, 2 STALL, 3 timeout, 4 CRC, 5 bit-stuff |
| rsp_len | input | MAXP_W | Length of a received data packet |
| ack_pulse | output | 1 | Request to return an acknowledge to the device |
| rx_irq | output | 1 | Receive interrupt pulse |
| req_bit | output | 1 | Request bit state |
| rx_rdy | output | 1 | Packet ready in the FIFO |
| auto_req | output | 1 | Auto-request state |
| stalled | output | 1 | Sticky STALL flag |
| err_flag | output | 1 | Sticky error-limit flag |
| nak_to | output | 1 | Sticky NAK-limit flag |
| pkt_cnt | output | CNT_W | Remaining packet budget |

## Verification
`tok_req` is derived from registered state. It therefore appears in the same cycle as the request bit it follows, one clock after `req_set` or after the unload that re-armed it. Every effect of a response (`rx_rdy`, `rx_irq`, the flags, the request bit, `auto_req`) lands one clock after the cycle in which `rsp_valid` was high. `ack_pulse` and the fall of `rx_rdy` land one clock after the clear or the final read.

The bench drives and samples on falling edges. After each driven pulse it samples at the very next falling edge, which is where each of those results first appears. Its engine model waits for a token before it answers, counts attempts, and compares the counts with the NAK limit, the error limit and the packet budget it has programmed.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

  typedef enum logic [2:0] {
    RSP_DATA  = 3'd0,
    RSP_NAK   = 3'd1,
    RSP_STALL = 3'd2,
    RSP_TMO   = 3'd3,
    RSP_CRC   = 3'd4,
    RSP_STUFF = 3'd5
  } rsp_e;

  typedef enum logic {ST_IDLE, ST_WAIT} seq_st_e;

  // packet shorter than the programmed payload ends an open-ended run
  function automatic logic is_short(logic [15:0] len, logic [15:0] maxp);
    return len < maxp;
  endfunction

  // a nonzero limit is reached when the next count equals it
  function automatic logic limit_reached(logic [15:0] cnt_next, logic [15:0] lim);
    return (lim != 16'd0) && (cnt_next == lim);
  endfunction

  // a bus-level error outcome (anything other than data, NAK, STALL)
  function automatic logic is_bus_err(logic [2:0] code);
    return code >= 3'd3;
  endfunction

endpackage

// File: rtl/ep_retry_ctl.sv
module ep_retry_ctl #(
  parameter int NAKL_W    = 8,
  parameter int ERR_TRIES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              nak_ev,
  input  logic              err_ev,
  input  logic [NAKL_W-1:0] nak_limit,
  output logic              nak_hit,
  output logic              err_hit
);
  import usb_in_pkg::*;

  localparam int ERR_W = $clog2(ERR_TRIES + 1);

  logic [NAKL_W-1:0] nak_cnt;
  logic [NAKL_W-1:0] nak_inc;
  logic [ERR_W-1:0]  err_cnt;

  assign nak_inc = (&nak_cnt) ? nak_cnt : nak_cnt + 1'b1;
  assign nak_hit = nak_ev && limit_reached(16'(nak_inc), 16'(nak_limit));
  assign err_hit = err_ev && (err_cnt == ERR_W'(ERR_TRIES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nak_cnt <= '0;
      err_cnt <= '0;
    end else if (clr) begin
      nak_cnt <= '0;
      err_cnt <= '0;
    end else begin
      if (nak_ev) nak_cnt <= nak_hit ? '0 : nak_inc;
      if (err_ev) err_cnt <= err_hit ? '0 : err_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ep_pkt_budget.sv
module ep_pkt_budget #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             short_ev,
  input  logic             autoreq_wr,
  input  logic             autoreq_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] pkt_cnt,
  output logic             auto_req
);
  logic cnt_zero;
  logic cnt_last;

  assign cnt_zero = (pkt_cnt == '0);
  assign cnt_last = (pkt_cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_cnt  <= '0;
      auto_req <= 1'b0;
    end else begin
      if (cnt_wr)                pkt_cnt <= cnt_val;
      else if (arm && !cnt_zero) pkt_cnt <= pkt_cnt - 1'b1;

      if (autoreq_wr)                auto_req <= autoreq_val;
      else if (arm && cnt_last)      auto_req <= 1'b0;
      else if (short_ev && cnt_zero) auto_req <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_rx_hold.sv
module ep_rx_hold #(
  parameter int MAXP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_ev,
  input  logic [MAXP_W-1:0] len,
  input  logic [MAXP_W-1:0] max_pay,
  input  logic              auto_clr_en,
  input  logic              rd,
  input  logic              sw_clr,
  output logic              rx_rdy,
  output logic              rx_irq,
  output logic              ack_pulse,
  output logic              unload
);
  logic [MAXP_W-1:0] pkt_len;
  logic [MAXP_W-1:0] rd_cnt;
  logic              auto_hit;

  assign auto_hit = rx_rdy && rd && auto_clr_en && (pkt_len == max_pay)
                    && ((rd_cnt + 1'b1) == max_pay);
  assign unload   = rx_rdy && (sw_clr || auto_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rdy    <= 1'b0;
      rx_irq    <= 1'b0;
      ack_pulse <= 1'b0;
      pkt_len   <= '0;
      rd_cnt    <= '0;
    end else begin
      rx_irq    <= data_ev;
      ack_pulse <= unload;
      if (data_ev) begin
        rx_rdy  <= 1'b1;
        pkt_len <= len;
        rd_cnt  <= '0;
      end else begin
        if (unload) rx_rdy <= 1'b0;
        if (rx_rdy && rd) rd_cnt <= rd_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_in_ep_seq.sv
module usb_in_ep_seq #(
  parameter int MAXP_W    = 11,
  parameter int CNT_W     = 8,
  parameter int NAKL_W    = 8,
  parameter int ERR_TRIES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_set,
  input  logic              rxrdy_clr,
  input  logic              sts_clr,
  input  logic              auto_clr_en,
  input  logic              autoreq_wr,
  input  logic              autoreq_val,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [MAXP_W-1:0] max_pay,
  input  logic [NAKL_W-1:0] nak_limit,
  input  logic              fifo_rd,
  output logic              tok_req,
  input  logic              rsp_valid,
  input  logic [2:0]        rsp_code,
  input  logic [MAXP_W-1:0] rsp_len,
  output logic              ack_pulse,
  output logic              rx_irq,
  output logic              req_bit,
  output logic              rx_rdy,
  output logic              auto_req,
  output logic              stalled,
  output logic              err_flag,
  output logic              nak_to,
  output logic [CNT_W-1:0]  pkt_cnt
);
  import usb_in_pkg::*;

  seq_st_e st;

  // named internal events
  logic rsp_take;
  logic ev_data, ev_nak, ev_stall, ev_err;
  logic ev_short;
  logic sw_arm, rearm, arm;
  logic unload;
  logic nak_hit, err_hit;
  logic req_drop;

  assign tok_req  = (st == ST_IDLE) && req_bit && !rx_rdy;
  assign rsp_take = (st == ST_WAIT) && rsp_valid;
  assign ev_data  = rsp_take && (rsp_code == RSP_DATA);
  assign ev_nak   = rsp_take && (rsp_code == RSP_NAK);
  assign ev_stall = rsp_take && (rsp_code == RSP_STALL);
  assign ev_err   = rsp_take && is_bus_err(rsp_code);
  assign ev_short = ev_data && is_short(16'(rsp_len), 16'(max_pay));

  assign sw_arm   = req_set && !req_bit;
  assign rearm    = unload && auto_req;
  assign arm      = sw_arm || rearm;
  assign req_drop = ev_data || ev_stall || nak_hit || err_hit;

  ep_retry_ctl #(.NAKL_W(NAKL_W), .ERR_TRIES(ERR_TRIES)) u_retry (
    .clk(clk), .rst_n(rst_n),
    .clr(arm || ev_data),
    .nak_ev(ev_nak), .err_ev(ev_err),
    .nak_limit(nak_limit),
    .nak_hit(nak_hit), .err_hit(err_hit)
  );

  ep_pkt_budget #(.CNT_W(CNT_W)) u_budget (
    .clk(clk), .rst_n(rst_n),
    .arm(arm), .short_ev(ev_short),
    .autoreq_wr(autoreq_wr), .autoreq_val(autoreq_val),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .pkt_cnt(pkt_cnt), .auto_req(auto_req)
  );

  ep_rx_hold #(.MAXP_W(MAXP_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .data_ev(ev_data), .len(rsp_len), .max_pay(max_pay),
    .auto_clr_en(auto_clr_en), .rd(fifo_rd), .sw_clr(rxrdy_clr),
    .rx_rdy(rx_rdy), .rx_irq(rx_irq), .ack_pulse(ack_pulse),
    .unload(unload)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      req_bit  <= 1'b0;
      stalled  <= 1'b0;
      err_flag <= 1'b0;
      nak_to   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (tok_req)   st <= ST_WAIT;
        ST_WAIT: if (rsp_valid) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase

      if (req_drop) req_bit <= 1'b0;
      else if (arm) req_bit <= 1'b1;

      if (ev_stall)                stalled  <= 1'b1;
      else if (sts_clr || sw_arm)  stalled  <= 1'b0;
      if (err_hit)                 err_flag <= 1'b1;
      else if (sts_clr || sw_arm)  err_flag <= 1'b0;
      if (nak_hit)                 nak_to   <= 1'b1;
      else if (sts_clr || sw_arm)  nak_to   <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_seq_checker.sv
module ep_seq_checker #(
  parameter int CNT_W  = 8,
  parameter int NAKL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_req,
  input logic              rx_irq,
  input logic              rx_rdy,
  input logic              ack_pulse,
  input logic              req_bit,
  input logic              auto_req,
  input logic              autoreq_wr,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  pkt_cnt,
  input logic [NAKL_W-1:0] nak_limit,
  input logic              stalled,
  input logic              err_flag,
  input logic              nak_to,
  input logic              ev_stall
);
  assert_one_token_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tok_req |=> !tok_req);

  assert_irq_with_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_rdy);

  assert_ack_on_unload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> (!rx_rdy && $past(rx_rdy)));

  assert_budget_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_wr) && (pkt_cnt != $past(pkt_cnt))) |-> (pkt_cnt == $past(pkt_cnt) - 1'b1));

  assert_autoreq_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(auto_req) && !$past(autoreq_wr)) |-> ($past(pkt_cnt) <= CNT_W'(1)));

  assert_nak_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nak_to) |-> (!req_bit && ($past(nak_limit) != '0)));

  assert_stall_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> (stalled && !req_bit));

  assert_err_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !req_bit);
endmodule

bind usb_in_ep_seq ep_seq_checker #(.CNT_W(CNT_W), .NAKL_W(NAKL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_req(tok_req), .rx_irq(rx_irq),
  .rx_rdy(rx_rdy), .ack_pulse(ack_pulse), .req_bit(req_bit),
  .auto_req(auto_req), .autoreq_wr(autoreq_wr), .cnt_wr(cnt_wr),
  .pkt_cnt(pkt_cnt), .nak_limit(nak_limit), .stalled(stalled),
  .err_flag(err_flag), .nak_to(nak_to), .ev_stall(ev_stall)
);

// File: tb/tb_usb_in_ep_seq.sv
module tb_usb_in_ep_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_set = 0, rxrdy_clr = 0, sts_clr = 0, auto_clr_en = 0;
  logic autoreq_wr = 0, autoreq_val = 0, cnt_wr = 0;
  logic [7:0] cnt_val = '0;
  logic [10:0] max_pay = 11'd8;
  logic [7:0] nak_limit = '0;
  logic fifo_rd = 0, rsp_valid = 0;
  logic [2:0] rsp_code = '0;
  logic [10:0] rsp_len = '0;
  logic tok_req, ack_pulse, rx_irq, req_bit, rx_rdy, auto_req;
  logic stalled, err_flag, nak_to;
  logic [7:0] pkt_cnt;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  usb_in_ep_seq dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .rxrdy_clr(rxrdy_clr),
    .sts_clr(sts_clr), .auto_clr_en(auto_clr_en), .autoreq_wr(autoreq_wr),
    .autoreq_val(autoreq_val), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .max_pay(max_pay), .nak_limit(nak_limit), .fifo_rd(fifo_rd),
    .tok_req(tok_req), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_len(rsp_len), .ack_pulse(ack_pulse), .rx_irq(rx_irq),
    .req_bit(req_bit), .rx_rdy(rx_rdy), .auto_req(auto_req),
    .stalled(stalled), .err_flag(err_flag), .nak_to(nak_to),
    .pkt_cnt(pkt_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_arm();
    req_set = 1; @(negedge clk); req_set = 0;
  endtask

  task automatic do_clr();
    rxrdy_clr = 1; @(negedge clk); rxrdy_clr = 0;
  endtask

  task automatic do_read();
    fifo_rd = 1; @(negedge clk); fifo_rd = 0;
  endtask

  task automatic set_auto(input bit v);
    autoreq_wr = 1; autoreq_val = v; @(negedge clk); autoreq_wr = 0;
  endtask

  task automatic set_cnt(input int n);
    cnt_wr = 1; cnt_val = n[7:0]; @(negedge clk); cnt_wr = 0;
  endtask

  // engine model: wait for a token, then answer one cycle later
  task automatic serve(input int code, input int len, output bit got);
    got = 0;
    for (int i = 0; i < 8; i++) begin
      if (tok_req) begin got = 1; break; end
      @(negedge clk);
    end
    if (got) begin
      @(negedge clk);
      rsp_valid = 1; rsp_code = code[2:0]; rsp_len = len[10:0];
      @(negedge clk);
      rsp_valid = 0;
    end
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    bit got;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state and no token before arming
    chk("R1", "reset outputs", {tok_req, ack_pulse, rx_irq, req_bit, rx_rdy,
        auto_req, stalled, err_flag, nak_to}, 0);
    chk("R1", "reset pkt_cnt", pkt_cnt, 0);
    repeat (4) @(negedge clk);
    chk("R1", "no token unarmed", tok_req, 0);
    do_arm();
    chk("R1", "token after arm", tok_req, 1);
    @(negedge clk);
    chk("R1", "token one cycle", tok_req, 0);
    rsp_valid = 1; rsp_code = 3'd0; rsp_len = 11'd8;
    @(negedge clk); rsp_valid = 0;
    // R2
    chk("R2", "rx_rdy set", rx_rdy, 1);
    chk("R2", "irq pulse", rx_irq, 1);
    chk("R2", "req cleared", req_bit, 0);
    @(negedge clk);
    chk("R2", "irq one cycle", rx_irq, 0);
    // R3
    do_clr();
    chk("R3", "rx_rdy cleared", rx_rdy, 0);
    chk("R3", "ack pulse", ack_pulse, 1);
    chk("R3", "no rearm without auto", req_bit, 0);
    @(negedge clk);
    chk("R3", "ack one cycle", ack_pulse, 0);

    // R4 auto-clear sweep over payload sizes
    auto_clr_en = 1;
    for (int mp = 2; mp <= 6; mp++) begin
      max_pay = mp[10:0];
      do_arm(); serve(0, mp, got);
      for (int r = 1; r < mp; r++) do_read();
      chk("R4", "held before last read", rx_rdy, 1);
      do_read();
      chk("R4", "auto cleared", rx_rdy, 0);
      chk("R4", "auto ack", ack_pulse, 1);
      do_arm(); serve(0, mp - 1, got);
      for (int r = 0; r < mp + 2; r++) do_read();
      chk("R4", "short packet held", rx_rdy, 1);
      do_clr();
    end
    auto_clr_en = 0; max_pay = 11'd8;
    do_arm(); serve(0, 8, got);
    for (int r = 0; r < 8; r++) do_read();
    chk("R4", "disabled auto-clear held", rx_rdy, 1);
    do_clr();

    // R5 R6 packet budget sweep
    for (int n = 1; n <= 5; n++) begin
      set_cnt(n); set_auto(1);
      do_arm();
      chk("R6", "decrement on arm", pkt_cnt, n - 1);
      cnt = 0;
      for (int k = 0; k < 12; k++) begin
        serve(0, 8, got);
        if (!got) break;
        cnt++;
        do_clr();
        if (cnt < n) chk("R5", "rearmed on unload", req_bit, 1);
      end
      chk("R6", "packets delivered", cnt, n);
      chk("R6", "auto_req cleared", auto_req, 0);
      chk("R6", "budget empty", pkt_cnt, 0);
    end

    // R7 open-ended run ends on a short packet
    for (int full = 0; full <= 3; full++) begin
      set_cnt(0); set_auto(1);
      do_arm();
      for (int k = 0; k < full; k++) begin
        serve(0, 8, got); do_clr();
      end
      chk("R7", "auto_req kept", auto_req, 1);
      serve(0, 3, got);
      chk("R7", "short clears auto_req", auto_req, 0);
      do_clr();
      serve(0, 8, got);
      chk("R7", "no token after short", got, 0);
    end

    // R8 NAK limit sweep
    for (int lim = 1; lim <= 5; lim++) begin
      nak_limit = lim[7:0];
      do_arm();
      cnt = 0;
      for (int k = 0; k < 12; k++) begin
        serve(1, 0, got);
        if (!got) break;
        cnt++;
      end
      chk("R8", "nak attempts", cnt, lim);
      chk("R8", "nak_to set", nak_to, 1);
      chk("R8", "req cleared", req_bit, 0);
    end
    // R13 flag clear by software arm
    nak_limit = 0;
    do_arm();
    chk("R13", "arm clears nak_to", nak_to, 0);
    // R9 unlimited NAKs
    for (int k = 0; k < 20; k++) serve(1, 0, got);
    chk("R9", "still retrying", got, 1);
    chk("R9", "no nak_to", nak_to, 0);
    serve(0, 8, got);
    chk("R9", "data after naks", rx_rdy, 1);
    do_clr();

    // R10 stall
    do_arm(); serve(2, 0, got);
    chk("R10", "stalled set", stalled, 1);
    chk("R10", "req cleared", req_bit, 0);
    serve(2, 0, got);
    chk("R10", "no retry", got, 0);
    sts_clr = 1; @(negedge clk); sts_clr = 0;
    chk("R13", "sts_clr clears stalled", stalled, 0);

    // R11 error codes
    for (int c = 3; c <= 5; c++) begin
      do_arm();
      cnt = 0;
      for (int k = 0; k < 8; k++) begin
        serve(c, 0, got);
        if (!got) break;
        cnt++;
      end
      chk("R11", "error attempts", cnt, 3);
      chk("R11", "err_flag set", err_flag, 1);
      chk("R11", "req cleared", req_bit, 0);
    end
    sts_clr = 1; @(negedge clk); sts_clr = 0;
    chk("R13", "sts_clr clears err_flag", err_flag, 0);

    // R12 counters restart after success
    nak_limit = 8'd3;
    for (int rep = 0; rep < 3; rep++) begin
      do_arm();
      serve(1, 0, got); serve(1, 0, got);
      serve(4, 0, got); serve(3, 0, got);
      serve(0, 8, got);
      chk("R12", "data after partial retries", rx_rdy, 1);
      do_clr();
    end
    chk("R12", "no nak_to", nak_to, 0);
    chk("R12", "no err_flag", err_flag, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule